// File: doc/BRIEF.md
# Shared PCI Interrupt Router with System-Control Interrupt Merge

This block takes eight level-sensitive shared PCI interrupt request lines (named A to H, index 0 to 7) and spreads them over 24 global interrupt lines. Lines 0 to 15 feed a legacy interrupt controller. Each of these lines is the wired-OR of every request whose route byte is enabled and names that line. Lines 16 to 23 feed an I/O-APIC, and each request owns one of them alone. Request n always drives line 16+n, whatever its route byte holds.

A system-control interrupt level is also merged in. It is ORed onto one line chosen by a sparse 3-bit select code, which can name a legacy line or an APIC line. A simple register port holds the eight route bytes and the select byte. It raises a one-cycle pulse when a route byte is written, so that software can rebuild its routing view. All 24 outputs are registered.

Top module: `pirq_router`

## Requirements
- R1: After reset every route byte reads 0x80 (all requests disabled for legacy routing), the select byte reads 0x00, all 24 outputs are low and the change pulse is low.
- R2: Request n (n = 0..7) drives output line 16+n whenever it is high, independent of its route byte. It drives no other APIC line.
- R3: A route byte with bit 7 set keeps its request off every legacy line 0..15.
- R4: Legacy line k (0..15) is high when at least one request is high whose route byte has bit 7 clear and bits [4:0] equal to k. Several requests may share one line.
- R5: A route byte with bit 7 clear and a line field (bits [4:0]) of 16..31 keeps its request off every legacy line.
- R6: Register addresses 0..7 hold the route bytes of requests 0..7, and address 8 holds the select byte. Route bytes read bits [6:5] as zero and the select byte reads bits [7:3] as zero. Addresses 9..15 read zero, and writes to them change nothing.
- R7: `route_changed_o` is high for exactly one cycle after a write to address 0..7. A write to any other address does not raise it.
- R8: Select codes 0, 1, 2, 4 and 5 put the system-control level on lines 9, 10, 11, 20 and 21. There it is ORed with any request that also drives that line.
- R9: Select codes 3, 6 and 7 are reserved and put the system-control level on no line.
- R10: The stored system-control level clears on reset, and an input held high through reset reaches its line only on the second edge after release. In general, a change of a request input reaches the outputs at the next clock edge. A register write or a change of the system-control input reaches them at the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| pirq_i | input | 8 | Shared PCI request levels, bit n is request n |
| sci_i | input | 1 | System-control interrupt level |
| gsi_o | output | 24 | Registered global interrupt lines |
| route_changed_o | output | 1 | One-cycle pulse after a route-byte write |

## Verification
The hardest case to reach is a line that several sources drive at once. This is a legacy line shared by two enabled requests, or an APIC line that also carries the system-control level. Dropping any one source must leave the line high. The stimulus programs two route bytes to the same line and points the select code at line 20 while request 4 is active. It then releases the sources one at a time and checks the line after each step. The reserved select codes and out-of-range line fields are walked with every source active, so that a line that should stay low is shown to stay low.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int ROUTE_W   = 8;
  localparam int LINE_W    = 5;
  localparam int DIS_BIT   = 7;
  localparam int SEL_W     = 3;
  localparam logic [ROUTE_W-1:0] ROUTE_RESET = 8'h80;
  localparam logic [SEL_W-1:0]   SEL_RESET   = 3'd0;

  // sparse select decode: returns target line and a valid flag
  function automatic logic [LINE_W:0] sci_target(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    sci_target = {1'b1, 5'd9};
      3'd1:    sci_target = {1'b1, 5'd10};
      3'd2:    sci_target = {1'b1, 5'd11};
      3'd4:    sci_target = {1'b1, 5'd20};
      3'd5:    sci_target = {1'b1, 5'd21};
      default: sci_target = '0;
    endcase
  endfunction
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_router_pkg::*;
#(
  parameter int N_PIRQ = 8,
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [ROUTE_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [ROUTE_W-1:0]          rd_data,
  output logic [N_PIRQ*ROUTE_W-1:0]   routes_o,
  output logic [SEL_W-1:0]            sci_sel_o,
  output logic                        changed_o
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(N_PIRQ);
  localparam logic [ROUTE_W-1:0] ROUTE_MASK =
    ROUTE_W'((1 << DIS_BIT) | ((1 << LINE_W) - 1));

  logic [ROUTE_W-1:0] route_q [N_PIRQ];
  logic [SEL_W-1:0]   sel_q;

  genvar g;
  generate
    for (g = 0; g < N_PIRQ; g++) begin : g_route
      always_ff @(posedge clk) begin
        if (rst)
          route_q[g] <= ROUTE_RESET;
        else if (wr_en && wr_addr == ADDR_W'(g))
          route_q[g] <= wr_data & ROUTE_MASK;
      end
      assign routes_o[g*ROUTE_W +: ROUTE_W] = route_q[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= SEL_RESET;
      changed_o <= 1'b0;
    end else begin
      if (wr_en && wr_addr == SEL_ADDR)
        sel_q <= wr_data[SEL_W-1:0];
      changed_o <= wr_en && (wr_addr < SEL_ADDR);
    end
  end

  assign sci_sel_o = sel_q;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_PIRQ; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = route_q[i];
    if (rd_addr == SEL_ADDR) rd_data = ROUTE_W'(sel_q);
  end
endmodule

// File: rtl/pirq_legacy_or.sv
module pirq_legacy_or
  import pirq_router_pkg::*;
#(
  parameter int N_PIRQ   = 8,
  parameter int N_LEGACY = 16
) (
  input  logic [N_PIRQ*ROUTE_W-1:0] routes,
  input  logic [N_PIRQ-1:0]         pirq,
  output logic [N_LEGACY-1:0]       legacy
);
  genvar l;
  generate
    for (l = 0; l < N_LEGACY; l++) begin : g_line
      always_comb begin
        legacy[l] = 1'b0;
        for (int p = 0; p < N_PIRQ; p++)
          if (pirq[p] && !routes[p*ROUTE_W + DIS_BIT] &&
              routes[p*ROUTE_W +: LINE_W] == LINE_W'(l))
            legacy[l] = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/pirq_sci_merge.sv
module pirq_sci_merge
  import pirq_router_pkg::*;
#(
  parameter int GSI_W = 24
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             level,
  output logic [GSI_W-1:0] sci_vec
);
  logic [LINE_W:0] tgt;
  assign tgt = sci_target(sel);

  always_comb begin
    sci_vec = '0;
    for (int k = 0; k < GSI_W; k++)
      if (tgt[LINE_W] && tgt[LINE_W-1:0] == LINE_W'(k))
        sci_vec[k] = level;
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int N_PIRQ   = 8,
  parameter int N_LEGACY = 16,
  parameter int ADDR_W   = 4,
  localparam int GSI_W   = N_LEGACY + N_PIRQ
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [7:0]         rd_data,
  input  logic [N_PIRQ-1:0]  pirq_i,
  input  logic               sci_i,
  output logic [GSI_W-1:0]   gsi_o,
  output logic               route_changed_o
);
  logic [N_PIRQ*ROUTE_W-1:0] routes;
  logic [SEL_W-1:0]          sci_sel;
  logic [N_LEGACY-1:0]       legacy;
  logic [GSI_W-1:0]          sci_vec;
  logic                      sci_q;

  pirq_route_regs #(.N_PIRQ(N_PIRQ), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .routes_o(routes),
    .sci_sel_o(sci_sel), .changed_o(route_changed_o)
  );

  pirq_legacy_or #(.N_PIRQ(N_PIRQ), .N_LEGACY(N_LEGACY)) u_legacy (
    .routes(routes), .pirq(pirq_i), .legacy(legacy)
  );

  pirq_sci_merge #(.GSI_W(GSI_W)) u_sci (
    .sel(sci_sel), .level(sci_q), .sci_vec(sci_vec)
  );

  // stored SCI level: reloading an equal value leaves outputs untouched
  always_ff @(posedge clk) begin
    if (rst) begin
      sci_q <= 1'b0;
      gsi_o <= '0;
    end else begin
      sci_q <= sci_i;
      gsi_o <= {pirq_i, legacy} | sci_vec;
    end
  end
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int N_PIRQ = 8,
  parameter int N_LEGACY = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic [3:0]                 wr_addr,
  input logic [3:0]                 rd_addr,
  input logic [7:0]                 rd_data,
  input logic [N_PIRQ-1:0]          pirq_i,
  input logic                       sci_q,
  input logic [2:0]                 sci_sel,
  input logic [N_LEGACY+N_PIRQ-1:0] gsi_o,
  input logic                       route_changed_o
);
  assert_reset_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !route_changed_o);

  genvar n;
  generate
    for (n = 0; n < N_PIRQ; n++) begin : g_apic
      assert_apic_line_R2: assert property (@(posedge clk) disable iff (rst)
        $past(pirq_i[n]) |-> gsi_o[N_LEGACY+n]);
    end
  endgenerate

  // R4: no source active, no legacy line active
  assert_quiet_legacy_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(pirq_i) == '0 && !$past(sci_q)) |-> gsi_o[N_LEGACY-1:0] == '0);

  assert_pad_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_addr < 4'd8) |-> rd_data[6:5] == 2'b00);

  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(wr_addr) < 4'd8) |-> route_changed_o);

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    !($past(wr_en) && $past(wr_addr) < 4'd8) |-> !route_changed_o);

  assert_reserved_sel_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(sci_sel) inside {3'd3, 3'd6, 3'd7} && $past(pirq_i) == '0) |-> gsi_o == '0);
endmodule

bind pirq_router pirq_router_chk #(.N_PIRQ(N_PIRQ), .N_LEGACY(N_LEGACY)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
  .rd_data(rd_data), .pirq_i(pirq_i), .sci_q(sci_q), .sci_sel(sci_sel),
  .gsi_o(gsi_o), .route_changed_o(route_changed_o)
);

// File: tb/test_pirq_router.sv
module test_pirq_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [7:0]  pirq_i = '0;
  logic        sci_i = 1'b0;
  logic [23:0] gsi_o;
  logic        route_changed_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pirq_router i_pirq_router (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pirq_i(pirq_i), .sci_i(sci_i),
    .gsi_o(gsi_o), .route_changed_o(route_changed_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), d);
      chk("R1 route default", 32'(d), 32'h80);
    end
    rd(4'd8, d);
    chk("R1 select default", 32'(d), 32'h0);
    chk("R1 outputs", 32'(gsi_o), 32'h0);
    chk("R1 pulse", 32'(route_changed_o), 32'h0);
  endtask

  task automatic t_apic();
    for (int n = 0; n < 8; n++) begin
      pirq_i = 8'(1 << n);
      @(negedge clk);
      chk("R2 R3 apic only", 32'(gsi_o), 32'(24'(1) << (16 + n)));
    end
    pirq_i = '0;
    @(negedge clk);
  endtask

  task automatic t_legacy();
    wr(4'd0, 8'h05);
    wr(4'd1, 8'h05);
    wr(4'd2, 8'h07);
    settle();
    pirq_i = 8'b0000_0011;
    @(negedge clk);
    chk("R4 shared both", 32'(gsi_o), 32'h03_0020);
    pirq_i = 8'b0000_0010;
    @(negedge clk);
    chk("R4 shared one left", 32'(gsi_o), 32'h02_0020);
    pirq_i = 8'b0000_0100;
    @(negedge clk);
    chk("R4 line 7", 32'(gsi_o), 32'h04_0080);
    wr(4'd2, 8'h87);
    settle();
    chk("R3 disable bit", 32'(gsi_o), 32'h04_0000);
    pirq_i = '0;
    @(negedge clk);
  endtask

  task automatic t_high_line();
    wr(4'd3, 8'h12);
    settle();
    pirq_i = 8'b0000_1000;
    @(negedge clk);
    chk("R5 field above 15", 32'(gsi_o), 32'h08_0000);
    wr(4'd3, 8'h1F);
    settle();
    chk("R5 field 31", 32'(gsi_o), 32'h08_0000);
    pirq_i = '0;
    @(negedge clk);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(4'd4, 8'hFF);
    rd(4'd4, d);
    chk("R6 route pad bits", 32'(d), 32'h9F);
    wr(4'd8, 8'hFD);
    rd(4'd8, d);
    chk("R6 select pad bits", 32'(d), 32'h05);
    wr(4'd12, 8'h33);
    rd(4'd12, d);
    chk("R6 unused address", 32'(d), 32'h0);
    rd(4'd4, d);
    chk("R6 unused write ignored", 32'(d), 32'h9F);
    wr(4'd4, 8'h80);
    wr(4'd8, 8'h00);
  endtask

  task automatic t_pulse();
    wr(4'd6, 8'h83);
    chk("R7 pulse high", 32'(route_changed_o), 32'h1);
    @(negedge clk);
    chk("R7 pulse one cycle", 32'(route_changed_o), 32'h0);
    wr(4'd8, 8'h00);
    chk("R7 no pulse select", 32'(route_changed_o), 32'h0);
    wr(4'd10, 8'h01);
    chk("R7 no pulse unused", 32'(route_changed_o), 32'h0);
  endtask

  task automatic t_sci();
    logic [23:0] exp;
    sci_i = 1'b1;
    for (int s = 0; s < 8; s++) begin
      wr(4'd8, 8'(s));
      settle();
      case (s)
        0: exp = 24'(1) << 9;
        1: exp = 24'(1) << 10;
        2: exp = 24'(1) << 11;
        4: exp = 24'(1) << 20;
        5: exp = 24'(1) << 21;
        default: exp = '0;
      endcase
      chk((s == 3 || s > 5) ? "R9 reserved select" : "R8 select line", 32'(gsi_o), 32'(exp));
    end
    wr(4'd8, 8'd4);
    pirq_i = 8'b0001_0000;
    settle();
    chk("R8 sci with pirq", 32'(gsi_o), 32'h10_0000);
    sci_i = 1'b0;
    settle();
    chk("R8 pirq keeps line", 32'(gsi_o), 32'h10_0000);
    pirq_i = '0;
    sci_i = 1'b1;
    settle();
    chk("R8 sci keeps line", 32'(gsi_o), 32'h10_0000);
    sci_i = 1'b0;
    settle();
  endtask

  task automatic t_sci_reset();
    sci_i = 1'b1;
    do_reset();
    @(negedge clk);
    chk("R10 stored sci cleared", 32'(gsi_o), 32'h0);
    @(negedge clk);
    chk("R10 sci second edge", 32'(gsi_o), 32'h200);
    sci_i = 1'b0;
    settle();
    chk("R10 sci low", 32'(gsi_o), 32'h0);
  endtask

  initial begin
    t_reset();
    t_apic();
    t_legacy();
    t_high_line();
    t_regmap();
    t_pulse();
    t_sci();
    t_sci_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule